// File: doc/BRIEF.md
# Subchannel Method Dispatch Router

The router sits between a command-stream parser and a set of five execution engines. Each incoming register-write request carries a method number, a subchannel index, a 32-bit value and a count of the parameters still to come in its burst. An eight-entry binding table records which engine each subchannel talks to. Method 0 rewrites that table. Methods in a reserved low window are consumed inside the router. All higher methods go to the engine that is currently bound to the request's subchannel.

An engine write is held on the port of its target engine until that engine signals ready. While a write is held, the router lowers its upstream ready. Binds, reserved methods and dropped requests are accepted in a single cycle. Three error flags report reserved methods, subchannels bound to no known engine, and subchannel indices beyond the table. Each flag is a one-cycle pulse in the cycle after the request was accepted.

Top module: `mdr_router`

## Requirements
- R1: After reset no engine valid is high, req_ready_o is high, all error flags are low, and every subchannel is unbound, so a forward through any subchannel raises err_engine_o.
- R2: An accepted request with method 0 and a legal subchannel stores the engine selected by its value as that subchannel's binding. It drives no engine valid and no error flag.
- R3: An accepted request with method 1 to 0x3F and a legal subchannel reaches no engine and pulses err_unimpl_o in the following cycle.
- R4: An accepted request with method 0x40 or above, on a subchannel bound to a known engine, raises that engine's valid in the following cycle with the request's method and value.
- R5: Engine port order is bit 0 = 2D, 1 = 3D, 2 = compute, 3 = DMA copy, 4 = inline-to-memory. The identifiers are parameters with defaults 0x201, 0x301, 0x401, 0x501 and 0x601, and any other value is unknown.
- R6: The 3D port also presents, on e3d_remain_o, the remaining-parameter count of the write it holds.
- R7: A forwarded method on a subchannel bound to an unknown identifier reaches no engine and pulses err_engine_o in the following cycle.
- R8: A request whose subchannel is 8 or above is dropped, including a bind, which leaves the table unchanged. err_subch_o pulses in the following cycle.
- R9: A held engine write keeps its valid, method and value unchanged until its ready is high at a clock edge. req_ready_o is low while any engine valid is high.
- R10: At most one engine valid and at most one error flag are high in any cycle.
- R11: A later bind on a subchannel redirects the subchannel's subsequent forwarded methods to the newly bound engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Router can accept a request |
| req_method_i | input | 12 | Method number |
| req_subch_i | input | 4 | Subchannel index |
| req_value_i | input | 32 | Write value |
| req_remain_i | input | 8 | Parameters remaining in burst |
| eng_valid_o | output | 5 | Per-engine write valid |
| eng_ready_i | input | 5 | Per-engine ready |
| eng_method_o | output | 60 | Per-engine method, 12 bits each |
| eng_value_o | output | 160 | Per-engine value, 32 bits each |
| e3d_remain_o | output | 8 | Remaining count for the 3D port |
| err_unimpl_o | output | 1 | Reserved method pulse |
| err_engine_o | output | 1 | Unknown engine pulse |
| err_subch_o | output | 1 | Subchannel out of range pulse |

## Verification
Some properties are checked in every cycle: at most one engine valid and at most one error flag at a time, a stall never changing a held payload, no port being loaded while it is busy, reserved methods and error pulses never coinciding with a forward, and a bind landing in the table. Only the bench scenarios can show which engine a given subchannel reaches. That covers binding, rebinding, unbound subchannels after reset, the 0x3F/0x40 boundary, and an illegal bind index that must not alias onto a real entry. The bench also shows that a request waiting during a stall is taken once the engine releases.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  localparam int NUM_ENG = 5;

  typedef enum logic [2:0] {
    SEL_2D   = 3'd0,
    SEL_3D   = 3'd1,
    SEL_CMP  = 3'd2,
    SEL_DMA  = 3'd3,
    SEL_I2M  = 3'd4,
    SEL_NONE = 3'd7
  } eng_sel_e;
endpackage

// File: rtl/mdr_id_map.sv
module mdr_id_map
  import mdr_pkg::*;
#(
  parameter logic [31:0] ID_2D  = 32'h0000_0201,
  parameter logic [31:0] ID_3D  = 32'h0000_0301,
  parameter logic [31:0] ID_CMP = 32'h0000_0401,
  parameter logic [31:0] ID_DMA = 32'h0000_0501,
  parameter logic [31:0] ID_I2M = 32'h0000_0601
) (
  input  logic [31:0] id_i,
  output eng_sel_e    sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (id_i == ID_2D)  sel_o = SEL_2D;
    else if (id_i == ID_3D)  sel_o = SEL_3D;
    else if (id_i == ID_CMP) sel_o = SEL_CMP;
    else if (id_i == ID_DMA) sel_o = SEL_DMA;
    else if (id_i == ID_I2M) sel_o = SEL_I2M;
  end
endmodule

// File: rtl/mdr_bind_table.sv
module mdr_bind_table
  import mdr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  eng_sel_e         wsel_i,
  input  logic [IDX_W-1:0] ridx_i,
  output eng_sel_e         rsel_o
);
  eng_sel_e tbl_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tbl_q[g] <= SEL_NONE;
      else if (we_i && widx_i == IDX_W'(g))       tbl_q[g] <= wsel_i;
    end
  end

  assign rsel_o = tbl_q[ridx_i];

  AST_BIND_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tbl_q[$past(widx_i)] == $past(wsel_i)); // R2
endmodule

// File: rtl/mdr_eng_slot.sv
module mdr_eng_slot #(
  parameter int PAY_W = 44
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PAY_W-1:0] pay_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [PAY_W-1:0] pay_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pay_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      pay_o   <= pay_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_HOLD_PAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(pay_o)); // R9
  AST_NO_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o); // R9
endmodule

// File: rtl/mdr_router.sv
module mdr_router
  import mdr_pkg::*;
#(
  parameter int          MTH_W   = 12,
  parameter int          SUB_W   = 4,
  parameter int          RMN_W   = 8,
  parameter int          DEPTH   = 8,
  parameter int          RSV_LIM = 64,
  parameter logic [31:0] ID_2D   = 32'h0000_0201,
  parameter logic [31:0] ID_3D   = 32'h0000_0301,
  parameter logic [31:0] ID_CMP  = 32'h0000_0401,
  parameter logic [31:0] ID_DMA  = 32'h0000_0501,
  parameter logic [31:0] ID_I2M  = 32'h0000_0601
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [MTH_W-1:0]           req_method_i,
  input  logic [SUB_W-1:0]           req_subch_i,
  input  logic [31:0]                req_value_i,
  input  logic [RMN_W-1:0]           req_remain_i,
  output logic [NUM_ENG-1:0]         eng_valid_o,
  input  logic [NUM_ENG-1:0]         eng_ready_i,
  output logic [NUM_ENG*MTH_W-1:0]   eng_method_o,
  output logic [NUM_ENG*32-1:0]      eng_value_o,
  output logic [RMN_W-1:0]           e3d_remain_o,
  output logic                       err_unimpl_o,
  output logic                       err_engine_o,
  output logic                       err_subch_o
);
  localparam int TIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int P_W    = MTH_W + 32;
  localparam int P3_W   = P_W + RMN_W;

  logic              acc, sub_ok, is_bind, is_rsv, fwd, tbl_we;
  logic [TIDX_W-1:0] tidx;
  eng_sel_e          wsel, rsel;
  logic [NUM_ENG-1:0] load;

  assign req_ready_o = ~|eng_valid_o;
  assign acc     = req_valid_i & req_ready_o;
  assign sub_ok  = int'(req_subch_i) < DEPTH;
  assign tidx    = req_subch_i[TIDX_W-1:0];
  assign is_bind = req_method_i == '0;
  assign is_rsv  = !is_bind && (int'(req_method_i) < RSV_LIM);
  assign tbl_we  = acc & sub_ok & is_bind;
  assign fwd     = acc & sub_ok & !is_bind & !is_rsv;

  mdr_id_map #(
    .ID_2D(ID_2D), .ID_3D(ID_3D), .ID_CMP(ID_CMP), .ID_DMA(ID_DMA), .ID_I2M(ID_I2M)
  ) u_map (
    .id_i  (req_value_i),
    .sel_o (wsel)
  );

  mdr_bind_table #(.DEPTH(DEPTH)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we),
    .widx_i (tidx),
    .wsel_i (wsel),
    .ridx_i (tidx),
    .rsel_o (rsel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_unimpl_o <= 1'b0;
      err_engine_o <= 1'b0;
      err_subch_o  <= 1'b0;
    end else begin
      err_subch_o  <= acc & !sub_ok;
      err_unimpl_o <= acc & sub_ok & is_rsv;
      err_engine_o <= fwd & (rsel == SEL_NONE);
    end
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    assign load[e] = fwd & (rsel == eng_sel_e'(e));
    if (e == int'(SEL_3D)) begin : g_3d
      logic [P3_W-1:0] pay;
      mdr_eng_slot #(.PAY_W(P3_W)) u_slot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load[e]),
        .pay_i   ({req_remain_i, req_method_i, req_value_i}),
        .ready_i (eng_ready_i[e]),
        .valid_o (eng_valid_o[e]),
        .pay_o   (pay)
      );
      assign e3d_remain_o                  = pay[P3_W-1 -: RMN_W];
      assign eng_method_o[e*MTH_W +: MTH_W] = pay[P_W-1 -: MTH_W];
      assign eng_value_o[e*32 +: 32]        = pay[31:0];
    end else begin : g_std
      logic [P_W-1:0] pay;
      mdr_eng_slot #(.PAY_W(P_W)) u_slot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load[e]),
        .pay_i   ({req_method_i, req_value_i}),
        .ready_i (eng_ready_i[e]),
        .valid_o (eng_valid_o[e]),
        .pay_o   (pay)
      );
      assign eng_method_o[e*MTH_W +: MTH_W] = pay[P_W-1 -: MTH_W];
      assign eng_value_o[e*32 +: 32]        = pay[31:0];
    end
  end

  AST_ONE_ENGINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eng_valid_o)); // R10
  AST_ONE_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_unimpl_o, err_engine_o, err_subch_o})); // R10
  AST_RSV_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_method_i != '0 && int'(req_method_i) < RSV_LIM
    |=> eng_valid_o == '0); // R3
  AST_ERR_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_engine_o |-> eng_valid_o == '0); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eng_valid_o) && !(|(eng_valid_o & eng_ready_i)) |=> $stable(eng_valid_o)); // R9
endmodule

// File: tb/sim_mdr_router.sv
module sim_mdr_router;
  localparam int CLK_P = 10;
  localparam int NV    = 20;

  typedef struct packed {
    logic [11:0] m;
    logic [3:0]  s;
    logic [31:0] v;
    logic [7:0]  r;
    logic [4:0]  ev;   // expected engine valid
    logic [2:0]  ee;   // expected {subch, engine, unimpl}
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{12'h000, 4'd0,  32'h301,      8'd0, 5'b00000, 3'b000}, // R2 bind 3D
    '{12'h000, 4'd1,  32'h201,      8'd0, 5'b00000, 3'b000}, // R2 bind 2D
    '{12'h000, 4'd2,  32'h401,      8'd0, 5'b00000, 3'b000},
    '{12'h000, 4'd3,  32'h501,      8'd0, 5'b00000, 3'b000},
    '{12'h000, 4'd4,  32'h601,      8'd0, 5'b00000, 3'b000},
    '{12'h000, 4'd5,  32'h999,      8'd0, 5'b00000, 3'b000}, // unknown id
    '{12'h100, 4'd0,  32'hCAFE0001, 8'd5, 5'b00010, 3'b000}, // R6
    '{12'h040, 4'd1,  32'h11112222, 8'd0, 5'b00001, 3'b000}, // boundary
    '{12'h03F, 4'd1,  32'h0,        8'd0, 5'b00000, 3'b001}, // R3
    '{12'h001, 4'd2,  32'h0,        8'd0, 5'b00000, 3'b001},
    '{12'h7FF, 4'd2,  32'hABCD0003, 8'd0, 5'b00100, 3'b000},
    '{12'h0A0, 4'd3,  32'h0000DDDD, 8'd0, 5'b01000, 3'b000},
    '{12'h0B0, 4'd4,  32'h12345678, 8'd0, 5'b10000, 3'b000},
    '{12'h080, 4'd5,  32'h0,        8'd0, 5'b00000, 3'b010}, // R7
    '{12'h080, 4'd6,  32'h0,        8'd0, 5'b00000, 3'b010}, // R1 unbound
    '{12'h080, 4'd9,  32'h0,        8'd0, 5'b00000, 3'b100}, // R8
    '{12'h000, 4'd12, 32'h301,      8'd0, 5'b00000, 3'b100}, // R8 illegal bind
    '{12'h000, 4'd1,  32'h501,      8'd0, 5'b00000, 3'b000}, // R11 rebind
    '{12'h044, 4'd1,  32'h00000044, 8'd0, 5'b01000, 3'b000}, // R11 now DMA
    '{12'h080, 4'd4,  32'h00000480, 8'd0, 5'b10000, 3'b000}  // R8 entry 4 kept
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_method = '0;
  logic [3:0]  req_subch = '0;
  logic [31:0] req_value = '0;
  logic [7:0]  req_remain = '0;
  logic [4:0]  eng_valid;
  logic [4:0]  eng_ready = 5'b11111;
  logic [59:0] eng_method;
  logic [159:0] eng_value;
  logic [7:0]  e3d_remain;
  logic        err_unimpl, err_engine, err_subch;

  int n_tot = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  mdr_router u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_method_i (req_method),
    .req_subch_i  (req_subch),
    .req_value_i  (req_value),
    .req_remain_i (req_remain),
    .eng_valid_o  (eng_valid),
    .eng_ready_i  (eng_ready),
    .eng_method_o (eng_method),
    .eng_value_o  (eng_value),
    .e3d_remain_o (e3d_remain),
    .err_unimpl_o (err_unimpl),
    .err_engine_o (err_engine),
    .err_subch_o  (err_subch)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, returns at the following negedge
  task automatic send(input logic [11:0] m, input logic [3:0] s,
                      input logic [31:0] v, input logic [7:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_method = m; req_subch = s; req_value = v; req_remain = r;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run();
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 valid", 64'(eng_valid), 64'd0);
    chk("R1 errors", 64'({err_subch, err_engine, err_unimpl}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].m, VEC[i].s, VEC[i].v, VEC[i].r);
      if (VEC[i].ee[2])      tag = "R8";
      else if (VEC[i].ee[1]) tag = "R7";
      else if (VEC[i].ee[0]) tag = "R3";
      else if (VEC[i].ev != 0) tag = "R4";
      else                   tag = "R2";
      chk({tag, " valid"}, 64'(eng_valid), 64'(VEC[i].ev));
      chk({tag, " errors"}, 64'({err_subch, err_engine, err_unimpl}), 64'(VEC[i].ee));
      for (int e = 0; e < 5; e++) begin
        if (VEC[i].ev[e]) begin
          chk("R5 method", 64'(eng_method[e*12 +: 12]), 64'(VEC[i].m));
          chk("R5 value", 64'(eng_value[e*32 +: 32]), 64'(VEC[i].v));
          if (e == 1) chk("R6 remain", 64'(e3d_remain), 64'(VEC[i].r));
        end
      end
    end

    // R9 stall on DMA port with a second request waiting
    @(negedge clk);
    eng_ready[3] = 1'b0;
    send(12'h050, 4'd1, 32'h5050_0001, 8'd0);
    chk("R9 held valid", 64'(eng_valid), 64'b01000);
    chk("R9 ready low", 64'(req_ready), 64'd0);
    req_valid = 1'b1; req_method = 12'h060; req_subch = 4'd1; req_value = 32'h6060_0002;
    repeat (3) @(negedge clk);
    chk("R9 still held", 64'(eng_valid), 64'b01000);
    chk("R10 one valid", 64'($countones(eng_valid)), 64'd1);
    chk("R9 method stable", 64'(eng_method[3*12 +: 12]), 64'h050);
    chk("R9 value stable", 64'(eng_value[3*32 +: 32]), 64'h5050_0001);
    chk("R9 ready still low", 64'(req_ready), 64'd0);
    eng_ready[3] = 1'b1;
    @(negedge clk);
    chk("R9 released", 64'(eng_valid), 64'd0);
    chk("R9 ready back", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 queued valid", 64'(eng_valid), 64'b01000);
    chk("R9 queued method", 64'(eng_method[3*12 +: 12]), 64'h060);
    chk("R9 queued value", 64'(eng_value[3*32 +: 32]), 64'h6060_0002);
    @(negedge clk);
    chk("R9 drained", 64'(eng_valid), 64'd0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        n_tot++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule